// File: doc/BRIEF.md
# Latched Board Interrupt Aggregator

This block collects sixteen external interrupt request lines from a board into one pending register and drives one combined interrupt line toward the host processor. A request is recorded only when its line is high in a cycle where the matching enable bit is set. The recorded bit then stays set until software rewrites the pending register, whatever the line does afterwards. The combined output is high whenever some pending bit has its enable bit set.

Beside the interrupt logic the block holds ten plain storage words for board housekeeping: two LED data words, an LED control word, a switch word, three miscellaneous control words, a miscellaneous status word and two card-slot words. Each returns what was last written to it. All access goes through a simple synchronous register port. A write takes effect on the clock edge where the write strobe is high. Read data appears on the clock edge after the read strobe.

Top module: `brd_irq_agg`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: When input n (0..15) is high at a clock edge and enable bit n is set, pending bit n is 1 after that edge.
- R3: An input that is high while its enable bit is clear records nothing. Setting the enable bit after the input has returned low leaves the pending bit at 0.
- R4: A pending bit never clears because its input falls. Only a write to the pending register (offset 0xD0) can clear it.
- R5: A write to the pending register (0xD0) replaces its whole contents with the written value ANDed with the writable mask.
- R6: The enable register (0xC0) and the pending register (0xD0) store only the bits of mask 0x000FEEFF. Bits 8, 12 and 20..31 always read 0.
- R7: `irq_o` is high exactly when (pending AND enable) is nonzero. After a write to either register it reflects the new contents right after the write edge.
- R8: Pending bits 16..19 have no input and change only through software writes. When enabled they still raise `irq_o`.
- R9: If an input capture and a pending-register write fall on the same edge, the stored value is the written value ORed with the captured bit.
- R10: The storage words at 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 each return the last value written to them.
- R11: A read from any other offset returns zero. A write to any other offset changes no register.
- R12: `rd_data_o` is loaded on the edge where `rd_en_i` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, registered |
| irq_i | input | 16 | External interrupt request levels |
| irq_o | output | 1 | Combined interrupt to host |

## Verification
A hardware capture and a software rewrite of the pending register can land on the same clock edge. If the write were applied after the capture, the captured event would be lost. The bench provokes this by raising an enabled input on the same falling edge where it presents a pending write that holds a different bit. It then reads the register back and requires the written value ORed with the captured bit, and it requires `irq_o` to be high.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

    localparam int OFF_W    = 8;
    localparam int NSTORE   = 10;
    localparam logic [31:0] WR_MASK = 32'h000F_EEFF;

    localparam logic [OFF_W-1:0] OFF_ENABLE  = 8'hC0;
    localparam logic [OFF_W-1:0] OFF_PENDING = 8'hD0;

    // Offset of each plain storage word, indexed 0..NSTORE-1
    function automatic logic [OFF_W-1:0] store_off(input int idx);
        case (idx)
            0:       store_off = 8'h10;
            1:       store_off = 8'h14;
            2:       store_off = 8'h40;
            3:       store_off = 8'h60;
            4:       store_off = 8'h80;
            5:       store_off = 8'h84;
            6:       store_off = 8'h88;
            7:       store_off = 8'h90;
            8:       store_off = 8'hE0;
            9:       store_off = 8'hE4;
            default: store_off = 8'hFF;
        endcase
    endfunction

    function automatic logic is_mapped(input logic [OFF_W-1:0] off);
        logic hit;
        hit = (off == OFF_ENABLE) || (off == OFF_PENDING);
        for (int i = 0; i < NSTORE; i++) begin
            if (off == store_off(i)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
    parameter int NIN = 16,
    parameter int DW  = 32,
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NIN-1:0] irq_i,
    input  logic           en_wr_i,
    input  logic           pend_wr_i,
    input  logic [DW-1:0]  wr_data_i,
    output logic [DW-1:0]  en_q_o,
    output logic [DW-1:0]  pend_q_o,
    output logic           irq_o
);

    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] pend;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [DW-1:0] cap;

    always_comb begin
        st_d = st_q;
        cap  = '0;
        // capture uses the enable value held before this edge
        cap[NIN-1:0] = irq_i & st_q.en[NIN-1:0];
        if (en_wr_i) begin
            st_d.en = wr_data_i & MASK;
        end
        if (pend_wr_i) begin
            st_d.pend = wr_data_i & MASK;
        end
        // software value first, hardware capture merged on top
        st_d.pend = st_d.pend | (cap & MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q_o   = st_q.en;
    assign pend_q_o = st_q.pend;
    assign irq_o    = |(st_q.pend & st_q.en);

endmodule

// File: rtl/brd_irq_store.sv
module brd_irq_store #(
    parameter int NREG = 10,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [DW-1:0]            wr_data_i,
    output logic [NREG-1:0][DW-1:0]  regs_o
);

    import brd_irq_pkg::*;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] word;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        localparam logic [AW-1:0] MY_OFF = AW'(store_off(g));
        assign hit[g] = wr_en_i && (addr_i == MY_OFF);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) st_d.word[i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.word;

endmodule

// File: rtl/brd_irq_rdmux.sv
module brd_irq_rdmux #(
    parameter int NREG = 10,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     rd_en_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [NREG-1:0][DW-1:0]  regs_i,
    input  logic [DW-1:0]            en_i,
    input  logic [DW-1:0]            pend_i,
    output logic [DW-1:0]            rd_data_o
);

    import brd_irq_pkg::*;

    typedef struct packed {
        logic [DW-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr_i == AW'(store_off(i))) sel = sel | regs_i[i];
        end
        if (addr_i == AW'(OFF_ENABLE))  sel = sel | en_i;
        if (addr_i == AW'(OFF_PENDING)) sel = sel | pend_i;
        st_d = st_q;
        if (rd_en_i) st_d.data = sel;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;

endmodule

// File: rtl/brd_irq_agg.sv
module brd_irq_agg #(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int NIN = 16
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [AW-1:0]  addr_i,
    input  logic           wr_en_i,
    input  logic [DW-1:0]  wr_data_i,
    input  logic           rd_en_i,
    output logic [DW-1:0]  rd_data_o,
    input  logic [NIN-1:0] irq_i,
    output logic           irq_o
);

    import brd_irq_pkg::*;

    localparam int NREG = NSTORE;
    localparam logic [DW-1:0] MASK = DW'(WR_MASK);

    logic                    en_wr, pend_wr;
    logic [DW-1:0]           en_q, pend_q;
    logic [NREG-1:0][DW-1:0] regs;

    assign en_wr   = wr_en_i && (addr_i == AW'(OFF_ENABLE));
    assign pend_wr = wr_en_i && (addr_i == AW'(OFF_PENDING));

    brd_irq_core #(.NIN(NIN), .DW(DW), .MASK(MASK)) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .irq_i     (irq_i),
        .en_wr_i   (en_wr),
        .pend_wr_i (pend_wr),
        .wr_data_i (wr_data_i),
        .en_q_o    (en_q),
        .pend_q_o  (pend_q),
        .irq_o     (irq_o)
    );

    brd_irq_store #(.NREG(NREG), .AW(AW), .DW(DW)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .regs_o    (regs)
    );

    brd_irq_rdmux #(.NREG(NREG), .AW(AW), .DW(DW)) u_rdmux (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .regs_i    (regs),
        .en_i      (en_q),
        .pend_i    (pend_q),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/brd_irq_agg_chk.sv
module brd_irq_agg_chk #(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int NIN = 16
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [AW-1:0]  addr_i,
    input logic           wr_en_i,
    input logic [DW-1:0]  wr_data_i,
    input logic           rd_en_i,
    input logic [DW-1:0]  rd_data_o,
    input logic [NIN-1:0] irq_i,
    input logic           irq_o,
    input logic [DW-1:0]  en_q,
    input logic [DW-1:0]  pend_q
);

    import brd_irq_pkg::*;

    localparam logic [DW-1:0] MASK = DW'(WR_MASK);

    logic pend_wr, en_wr;
    logic [NIN-1:0] arm;
    assign pend_wr = wr_en_i && (addr_i == AW'(OFF_PENDING));
    assign en_wr   = wr_en_i && (addr_i == AW'(OFF_ENABLE));
    assign arm     = irq_i & en_q[NIN-1:0];

    // R2
    capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_q[NIN-1:0] & $past(arm)) == $past(arm)));

    // R4
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R6
    en_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_wr |=> (en_q == ($past(wr_data_i) & MASK)));

    // R7
    irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_wr && (wr_data_i == '0)) |=> !irq_o);

    // R9
    merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_wr && (|arm)) |=>
            (pend_q[NIN-1:0] == (($past(wr_data_i[NIN-1:0]) & MASK[NIN-1:0]) | $past(arm))));

    // R11
    undef_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !is_mapped(OFF_W'(addr_i))) |=> (rd_data_o == '0));

    // R12
    rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

bind brd_irq_agg brd_irq_agg_chk #(.AW(AW), .DW(DW), .NIN(NIN)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .irq_i     (irq_i),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .pend_q    (pend_q)
);

// File: tb/brd_irq_agg_tb.sv
module brd_irq_agg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [15:0] irq_in = '0;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [31:0] M = 32'h000F_EEFF;
    logic [7:0] offs [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80,
                              8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};
    logic [31:0] exp_store [10];

    always #10 clk = ~clk;   // 50 MHz

    brd_irq_agg u_dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .irq_i(irq_in), .irq_o(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        irq_in[n] = 1'b1;
        @(negedge clk);
        irq_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
        for (int i = 0; i < 10; i++) begin
            rd(offs[i], v); chk("R1 store", v, 32'h0);
        end
        rd(8'hC0, v); chk("R1 enable", v, 32'h0);
        rd(8'hD0, v); chk("R1 pending", v, 32'h0);

        // R10 storage sweep
        for (int i = 0; i < 10; i++) begin
            exp_store[i] = (32'h1111_1111 * (i + 1)) ^ 32'hA5C3_0F96;
            wr(offs[i], exp_store[i]);
        end
        for (int i = 0; i < 10; i++) begin
            rd(offs[i], v); chk("R10 store", v, exp_store[i]);
        end

        // R11 undefined offsets
        wr(8'h00, 32'hDEAD_BEEF); wr(8'h44, 32'hDEAD_BEEF);
        wr(8'hC4, 32'hDEAD_BEEF); wr(8'hFF, 32'hDEAD_BEEF);
        for (int i = 0; i < 10; i++) begin
            rd(offs[i], v); chk("R11 no write effect", v, exp_store[i]);
        end
        rd(8'hC0, v); chk("R11 enable untouched", v, 32'h0);
        rd(8'hD0, v); chk("R11 pending untouched", v, 32'h0);
        rd(8'h00, v); chk("R11 undef read", v, 32'h0);
        rd(8'h44, v); chk("R11 undef read", v, 32'h0);
        rd(8'hD4, v); chk("R11 undef read", v, 32'h0);

        // R12 read data holds without strobe
        rd(8'h10, v);
        @(negedge clk); addr = 8'h14;
        @(negedge clk); chk("R12 hold", rd_data, exp_store[0]);

        // R6 writable mask
        wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, v); chk("R6 enable mask", v, M);
        wr(8'hD0, 32'hFFFF_FFFF); rd(8'hD0, v); chk("R6 pending mask", v, M);
        chk("R7 irq all", {31'b0, irq_out}, 32'h1);

        // R5 replace contents
        wr(8'hD0, 32'h0003_0201); rd(8'hD0, v); chk("R5 replace", v, 32'h0003_0201 & M);
        wr(8'hD0, 32'h0); rd(8'hD0, v); chk("R5 clear", v, 32'h0);
        chk("R7 irq after clear", {31'b0, irq_out}, 32'h0);

        // R2 / R4 / R7 capture sweep
        for (int n = 0; n < 16; n++) begin
            e = (32'h1 << n) & M;
            wr(8'hD0, 32'h0);
            wr(8'hC0, 32'h1 << n);
            pulse(n);
            rd(8'hD0, v); chk("R2 capture / R4 held after fall", v, e);
            chk("R7 irq level", {31'b0, irq_out}, {31'b0, |e});
        end

        // R3 event while disabled is lost
        for (int n = 0; n < 16; n += 5) begin
            wr(8'hD0, 32'h0);
            wr(8'hC0, 32'h0);
            pulse(n);
            wr(8'hC0, 32'hFFFF_FFFF);
            rd(8'hD0, v); chk("R3 not recorded", v, 32'h0);
            chk("R3 irq", {31'b0, irq_out}, 32'h0);
        end

        // R8 software-only bits
        for (int k = 16; k < 20; k++) begin
            wr(8'hD0, 32'h0);
            wr(8'hC0, 32'h1 << k);
            chk("R8 irq before set", {31'b0, irq_out}, 32'h0);
            wr(8'hD0, 32'h1 << k);
            chk("R8 irq", {31'b0, irq_out}, 32'h1);
            wr(8'hC0, 32'h0);
            chk("R7 irq disable", {31'b0, irq_out}, 32'h0);
        end

        // R9 capture and write on the same edge
        wr(8'hD0, 32'h0);
        wr(8'hC0, 32'h0000_0008);
        @(negedge clk);
        addr = 8'hD0; wr_data = 32'h0001_0000; wr_en = 1'b1; irq_in[3] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; irq_in = '0;
        rd(8'hD0, v); chk("R9 merge", v, 32'h0001_0008);
        chk("R9 irq", {31'b0, irq_out}, 32'h1);

        // R4 falling input does not clear, only a write
        wr(8'hD0, 32'h0);
        rd(8'hD0, v); chk("R4 write clears", v, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule